// File: doc/BRIEF.md
# ADC Digital Test Pattern Generator

This block produces test words that stand in for converter samples, so that a downstream receiver can prove its capture and timing without an analog input. On every sample clock it puts one word on a 16-bit parallel bus that feeds the output serializer. Words are left-aligned: the active bits sit at the top of the bus and every unused low bit is zero. A mode input selects the pattern and a length input selects the word width. The patterns are a raw-sample pass-through, fixed levels, alternating patterns, two pseudorandom sequences and rotations through four user-programmed words.

The two pseudorandom sequences step a shift register twelve bits per clock. The short one uses feedback x^9 + x^5 + 1 and the long one uses x^23 + x^18 + 1. Each starts from a fixed seed that is not all ones, and the long one is sent inverted. A one-cycle restart pulse puts both generators back at their seeds and sends the alternation back to its first word. A change of mode does the same. The receiver can therefore predict the stream exactly from a known starting point.

Top module: `tpg_top`

## Requirements
- R1: While `rst` is high, `wordOut` is zero. After reset, the first word of any mode is that mode's first word.
- R2: Mode 5 is the short sequence. Its words are always 12 bits in `wordOut[15:4]`, with `wordOut[3:0]` zero, whatever `lenSel` is. From the seed the first three words are 0xDF9, 0x353 and 0x301.
- R3: The short sequence repeats every 511 words (511 x 12 bits). Word 511 after a reload equals word 0.
- R4: Mode 6 is the long sequence. It is inverted, also 12 bits in `wordOut[15:4]`, and its first three words are 0x591, 0xFD7 and 0x0A3.
- R5: A `restart` sampled high at a clock edge reloads both seeds and sets the alternation phase to its first word. The word after that edge is the mode's first word.
- R6: A `modeSel` value that differs from the previous edge's value has the same effect as `restart`. This is also true when both happen at the same edge.
- R7: The word length is `lenSel`, clamped to the range 8 to 14. It applies to every mode except 5 and 6. Only the top N bits of `wordOut` may be nonzero.
- R8: Mode 8 alternates `user0`, `user1`, `user0`, and so on. Each word is truncated to the top N bits.
- R9: Mode 9 rotates `user0`, `user1`, `user2`, `user3` and then repeats. Each word is truncated to the top N bits.
- R10: Mode 4 alternates 0xAAAA and 0x5555. Mode 7 alternates all ones and all zeros. Both start with the first value and are truncated to N bits.
- R11: Fixed levels: mode 1 is midscale (only bit 15 set), mode 2 is all ones, and mode 3 is all zeros. Each is truncated to N bits.
- R12: Mode 0 passes `sampleIn` to `wordOut[15:2]`, truncated to N bits. Modes 10 to 15 give zero. Each word appears on the edge that samples its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Reload seeds and alternation phase |
| modeSel | input | 4 | Pattern select (encoding in R2 to R12) |
| lenSel | input | 4 | Word length, clamped to 8 to 14 |
| sampleIn | input | 14 | Converter sample used by mode 0 |
| user0 | input | 16 | First user word |
| user1 | input | 16 | Second user word |
| user2 | input | 16 | Third user word |
| user3 | input | 16 | Fourth user word |
| wordOut | output | 16 | Left-aligned test word, one per clock |

## Verification
A restart pulse and a mode change can land on the same clock edge. Each also has to win over the ordinary advance of the generators and of the alternation phase. The bench provokes this by raising `restart` in the same cycle that it switches from the long to the short sequence. It also restarts the user rotations part-way through a cycle, and restarts the long sequence while it is running. A behavioural model built from bit queues predicts every word, and explicit checks require the seed's first word right after each of these edges.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int WORD_W     = 16;
  localparam int SAMPLE_W   = 14;
  localparam int PN_W       = 12;
  localparam int LEN_W      = 4;
  localparam int MODE_W     = 4;
  localparam int MIN_LEN    = 8;
  localparam int MAX_LEN    = 14;
  localparam int NUM_USER   = 4;
  localparam int PHASE_W    = $clog2(NUM_USER);
  localparam int SHORT_LEN  = 9;
  localparam int SHORT_TAP  = 5;
  localparam int LONG_LEN   = 23;
  localparam int LONG_TAP   = 18;
  localparam logic [SHORT_LEN-1:0] SHORT_SEED = 9'h0DF;
  localparam logic [LONG_LEN-1:0]  LONG_SEED  = 23'h29B80A;

  typedef enum logic [MODE_W-1:0] {
    MODE_PASS     = 4'd0,
    MODE_MID      = 4'd1,
    MODE_POSFS    = 4'd2,
    MODE_NEGFS    = 4'd3,
    MODE_CHECKER  = 4'd4,
    MODE_PN_SHORT = 4'd5,
    MODE_PN_LONG  = 4'd6,
    MODE_TOGGLE   = 4'd7,
    MODE_USER_ALT = 4'd8,
    MODE_USER_CYC = 4'd9
  } tpgMode_e;

  typedef struct packed {
    logic               loadSeed;
    logic [PHASE_W-1:0] phase;
  } tpgCtl_s;
endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int LEN = 9,
  parameter int TAP = 5,
  parameter logic [LEN-1:0] SEED = '1,
  parameter int STEPS = 12,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadSeed,
  output logic [STEPS-1:0] chunk
);
  logic [LEN-1:0]   state;
  logic [LEN-1:0]   nextState;
  logic [STEPS-1:0] rawBits;

  // Unrolled bit steps: shift left, feedback into bit 0, emit the new MSB.
  always_comb begin
    nextState = loadSeed ? SEED : state;
    rawBits   = '0;
    for (int i = 0; i < STEPS; i++) begin
      nextState = {nextState[LEN-2:0], nextState[LEN-1] ^ nextState[TAP-1]};
      rawBits[STEPS-1-i] = nextState[LEN-1];
    end
  end

  generate
    if (INVERT) begin : g_inv
      assign chunk = ~rawBits;
    end else begin : g_true
      assign chunk = rawBits;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= nextState;
  end
endmodule

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
#(
  parameter int MODE_BITS = MODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 restart,
  input  logic [MODE_BITS-1:0] modeSel,
  output tpgCtl_s              ctl
);
  logic [MODE_BITS-1:0] prevMode;
  logic [PHASE_W-1:0]   phaseReg;
  logic                 reload;

  assign reload       = restart || (modeSel != prevMode);
  assign ctl.loadSeed = reload;
  assign ctl.phase    = reload ? '0 : phaseReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevMode <= '0;
      phaseReg <= '0;
    end else begin
      prevMode <= modeSel;
      phaseReg <= ctl.phase + 1'b1;
    end
  end
endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int SW    = SAMPLE_W,
  parameter int LW    = LEN_W,
  parameter int NU    = NUM_USER
) (
  input  logic                clk,
  input  logic                rst,
  input  tpgCtl_s             ctl,
  input  logic [MODE_W-1:0]   modeSel,
  input  logic [LW-1:0]       lenSel,
  input  logic [SW-1:0]       sampleIn,
  input  logic [NU-1:0][W-1:0] userWords,
  output logic [W-1:0]        wordOut
);
  localparam int PAD_PN  = W - PN_W;
  localparam int PAD_SMP = W - SW;

  logic [PN_W-1:0] shortChunk;
  logic [PN_W-1:0] longChunk;
  logic [LW-1:0]   effLen;
  logic [W-1:0]    lenMask;
  logic [W-1:0]    pnMask;
  logic [W-1:0]    rawWord;
  logic            isPn;
  tpgMode_e        mode;

  tpg_lfsr #(.LEN(SHORT_LEN), .TAP(SHORT_TAP), .SEED(SHORT_SEED),
             .STEPS(PN_W), .INVERT(1'b0)) u_short (
    .clk(clk), .rst(rst), .loadSeed(ctl.loadSeed), .chunk(shortChunk));

  tpg_lfsr #(.LEN(LONG_LEN), .TAP(LONG_TAP), .SEED(LONG_SEED),
             .STEPS(PN_W), .INVERT(1'b1)) u_long (
    .clk(clk), .rst(rst), .loadSeed(ctl.loadSeed), .chunk(longChunk));

  assign mode = tpgMode_e'(modeSel);

  always_comb begin
    if (lenSel < LW'(MIN_LEN))      effLen = LW'(MIN_LEN);
    else if (lenSel > LW'(MAX_LEN)) effLen = LW'(MAX_LEN);
    else                            effLen = lenSel;
  end

  assign lenMask = ~({W{1'b1}} >> effLen);
  assign pnMask  = {{PN_W{1'b1}}, {PAD_PN{1'b0}}};

  always_comb begin
    isPn = 1'b0;
    case (mode)
      MODE_PASS:     rawWord = {sampleIn, {PAD_SMP{1'b0}}};
      MODE_MID:      rawWord = {1'b1, {(W-1){1'b0}}};
      MODE_POSFS:    rawWord = '1;
      MODE_NEGFS:    rawWord = '0;
      MODE_CHECKER:  rawWord = ctl.phase[0] ? {(W/2){2'b01}} : {(W/2){2'b10}};
      MODE_PN_SHORT: begin rawWord = {shortChunk, {PAD_PN{1'b0}}}; isPn = 1'b1; end
      MODE_PN_LONG:  begin rawWord = {longChunk, {PAD_PN{1'b0}}};  isPn = 1'b1; end
      MODE_TOGGLE:   rawWord = ctl.phase[0] ? '0 : '1;
      MODE_USER_ALT: rawWord = userWords[{{(PHASE_W-1){1'b0}}, ctl.phase[0]}];
      MODE_USER_CYC: rawWord = userWords[ctl.phase];
      default:       rawWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) wordOut <= '0;
    else     wordOut <= rawWord & (isPn ? pnMask : lenMask);
  end
endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic [MODE_W-1:0]   modeSel,
  input  logic [LEN_W-1:0]    lenSel,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [WORD_W-1:0]   user0,
  input  logic [WORD_W-1:0]   user1,
  input  logic [WORD_W-1:0]   user2,
  input  logic [WORD_W-1:0]   user3,
  output logic [WORD_W-1:0]   wordOut
);
  tpgCtl_s ctl;
  logic [NUM_USER-1:0][WORD_W-1:0] userWords;

  assign userWords = {user3, user2, user1, user0};

  tpg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .restart(restart), .modeSel(modeSel), .ctl(ctl));

  tpg_datapath u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .modeSel(modeSel), .lenSel(lenSel),
    .sampleIn(sampleIn), .userWords(userWords), .wordOut(wordOut));
endmodule

// File: rtl/tpg_chk.sv
module tpg_chk (
  input logic        clk,
  input logic        rst,
  input logic        restart,
  input logic [3:0]  modeSel,
  input logic [3:0]  lenSel,
  input logic [15:0] wordOut
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> wordOut == 16'h0000);

  // R2
  pn_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 4'd5 || modeSel == 4'd6) |=> wordOut[3:0] == 4'h0);

  // R5
  restart_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && modeSel == 4'd5) |=> wordOut == 16'hDF90);

  // R6
  mode_switch_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 4'd6 && modeSel != $past(modeSel)) |=> wordOut == 16'h5910);

  // R7
  short_len_chk: assert property (@(posedge clk) disable iff (rst)
    (lenSel <= 4'd8 && modeSel != 4'd5 && modeSel != 4'd6) |=> wordOut[7:0] == 8'h00);

  // R11
  full_scale_chk: assert property (@(posedge clk) disable iff (rst)
    modeSel == 4'd2 |=> wordOut[15:8] == 8'hFF);
endmodule

bind tpg_top tpg_chk u_chk (.*);

// File: tb/tb_tpg_top.sv
module tb_tpg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        restart = 1'b0;
  logic [3:0]  modeSel = 4'd5;
  logic [3:0]  lenSel = 4'd12;
  logic [13:0] sampleIn = '0;
  logic [15:0] user0 = 16'h1234, user1 = 16'hABCD, user2 = 16'hF00F, user3 = 16'h0FF1;
  logic [15:0] wordOut;

  int checks = 0;
  int fails = 0;

  tpg_top dut (.clk(clk), .rst(rst), .restart(restart), .modeSel(modeSel),
               .lenSel(lenSel), .sampleIn(sampleIn), .user0(user0), .user1(user1),
               .user2(user2), .user3(user3), .wordOut(wordOut));

  always #4 clk = ~clk;

  // Behavioural reference: bit queues following the recurrences.
  bit sQ[$];
  bit lQ[$];
  int sRd, lRd;
  int idx;
  logic [3:0]  modelPrev;
  logic [3:0]  lastMode;
  logic [15:0] expWord;

  function automatic void pnInit();
    logic [8:0]  s = 9'h0DF;
    logic [22:0] l = 23'h29B80A;
    sQ.delete(); lQ.delete();
    for (int i = 8; i >= 0; i--) sQ.push_back(s[i]);
    for (int i = 22; i >= 0; i--) lQ.push_back(l[i]);
    sRd = 1; lRd = 1;
  endfunction

  function automatic logic [11:0] pnShort();
    logic [11:0] w = '0;
    for (int i = 0; i < 12; i++) begin
      while (sRd >= sQ.size()) sQ.push_back(sQ[sQ.size()-9] ^ sQ[sQ.size()-5]);
      w = {w[10:0], sQ[sRd]};
      sRd++;
    end
    while (sRd > 40) begin void'(sQ.pop_front()); sRd--; end
    return w;
  endfunction

  function automatic logic [11:0] pnLong();
    logic [11:0] w = '0;
    for (int i = 0; i < 12; i++) begin
      while (lRd >= lQ.size()) lQ.push_back(lQ[lQ.size()-23] ^ lQ[lQ.size()-18]);
      w = {w[10:0], lQ[lRd]};
      lRd++;
    end
    while (lRd > 60) begin void'(lQ.pop_front()); lRd--; end
    return ~w;
  endfunction

  function automatic logic [15:0] lenMaskOf(logic [3:0] len);
    int n = (len < 8) ? 8 : (len > 14) ? 14 : int'(len);
    logic [15:0] m = '0;
    for (int b = 0; b < n; b++) m[15-b] = 1'b1;
    return m;
  endfunction

  function automatic string reqOf(logic [3:0] m);
    case (m)
      4'd1, 4'd2, 4'd3: return "R11";
      4'd4, 4'd7:       return "R10";
      4'd5:             return "R2";
      4'd6:             return "R4";
      4'd8:             return "R8";
      4'd9:             return "R9";
      default:          return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    logic [11:0] sw, lw;
    logic [15:0] raw, m;
    if (rst) begin
      modelPrev = 4'd0; idx = -1; pnInit(); expWord = '0; lastMode = modeSel;
    end else begin
      if (restart || modeSel != modelPrev) begin idx = 0; pnInit(); end
      else idx++;
      sw = pnShort(); lw = pnLong();
      m = lenMaskOf(lenSel);
      case (modeSel)
        4'd0: raw = {sampleIn, 2'b00};
        4'd1: raw = 16'h8000;
        4'd2: raw = 16'hFFFF;
        4'd3: raw = 16'h0000;
        4'd4: raw = (idx % 2 == 0) ? 16'hAAAA : 16'h5555;
        4'd5: begin raw = {sw, 4'h0}; m = 16'hFFF0; end
        4'd6: begin raw = {lw, 4'h0}; m = 16'hFFF0; end
        4'd7: raw = (idx % 2 == 0) ? 16'hFFFF : 16'h0000;
        4'd8: raw = (idx % 2 == 0) ? user0 : user1;
        4'd9: case (idx % 4) 0: raw = user0; 1: raw = user1; 2: raw = user2; default: raw = user3; endcase
        default: raw = 16'h0000;
      endcase
      expWord = raw & m;
      modelPrev = modeSel;
      lastMode = modeSel;
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: wordOut=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock; compare against the model at the falling edge.
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    check(rst ? "R1" : reqOf(lastMode), wordOut, expWord);
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: wordOut=%h expected=none", wordOut);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) cycle();
    check("R1", wordOut, 16'h0000);
    rst = 1'b0;
    // R2: first words of short sequence, then R3: period 511 words
    cycle(); check("R2", wordOut, 16'hDF90);
    cycle(); check("R2", wordOut, 16'h3530);
    cycle(); check("R2", wordOut, 16'h3010);
    repeat (508) cycle();
    cycle(); check("R3", wordOut, 16'hDF90);
    cycle(); check("R3", wordOut, 16'h3530);
    // R6 + R4: switch to long sequence; length has no effect on PN modes
    modeSel = 4'd6; lenSel = 4'd8;
    cycle(); check("R4", wordOut, 16'h5910); check("R6", wordOut, 16'h5910);
    cycle(); check("R4", wordOut, 16'hFD70);
    cycle(); check("R4", wordOut, 16'h0A30);
    repeat (20) cycle();
    // R5: restart mid-run
    restart = 1'b1; cycle(); check("R5", wordOut, 16'h5910);
    restart = 1'b0; cycle(); check("R5", wordOut, 16'hFD70);
    repeat (5) cycle();
    // R5 and R6 at the same edge
    restart = 1'b1; modeSel = 4'd5; cycle(); check("R6", wordOut, 16'hDF90);
    restart = 1'b0; cycle(); check("R5", wordOut, 16'h3530);
    // R8: user alternation, restart at odd phase
    modeSel = 4'd8; lenSel = 4'd14;
    cycle(); check("R8", wordOut, 16'h1234);
    cycle(); check("R8", wordOut, 16'hABCC);
    restart = 1'b1; cycle(); check("R5", wordOut, 16'h1234);
    restart = 1'b0; repeat (3) cycle();
    // R9: four-word rotation at length 10, restart part way
    modeSel = 4'd9; lenSel = 4'd10;
    repeat (3) cycle();
    restart = 1'b1; cycle(); check("R9", wordOut, 16'h1200);
    restart = 1'b0; repeat (6) cycle();
    // R7: length sweep in pass-through with varied samples
    modeSel = 4'd0;
    for (int len = 0; len < 16; len++) begin
      lenSel = 4'(len);
      sampleIn = 14'h3FFF ^ 14'(len * 733);
      cycle();
      check("R7", wordOut & ~lenMaskOf(4'(len)), 16'h0000);
    end
    // R10, R11: fixed and alternating levels at several lengths
    for (int m = 1; m <= 7; m++) begin
      if (m == 5 || m == 6) continue;
      modeSel = 4'(m);
      for (int l = 8; l <= 14; l += 3) begin
        lenSel = 4'(l);
        repeat (3) cycle();
      end
    end
    // R12: unused codes give zero
    sampleIn = 14'h2AB5;
    for (int m = 10; m < 16; m++) begin
      modeSel = 4'(m);
      cycle(); check("R12", wordOut, 16'h0000);
    end
    // R12: pass-through alignment
    modeSel = 4'd0; lenSel = 4'd14;
    cycle(); check("R12", wordOut, 16'hAAD4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule